// File: doc/BRIEF.md
# Read-Path Standby and Automatic Sleep Controller

This block tracks the power state of a memory read path. It watches the chip-select, the device reset, the output-enable strobe, the read address and a busy flag from the program/erase engine. From these it reports one of three states: active, standby or sleep. It also drives the enable for the data bus drivers, a hold signal that keeps the last read data latched, and a flag that tells the access logic whether the next read must take the full chip-select latency or the normal address latency.

Standby is entered when the part is deselected, its reset input is inactive, and no program or erase is running. A program or erase that is still running keeps the block active even after deselection. Automatic sleep depends only on the address. Once the address has been stable for a configurable number of clock cycles, the block enters sleep and the read data stays latched and readable. Any address change wakes it at once. All thresholds are counted in clock cycles.

Top module: `rd_pwr_mgr`

## Requirements
- R1: After the block's own reset (`rst_ni` low), `state_o` is standby (2'd1), `drv_en_o` is 0, `hold_o` is 0 and `full_lat_o` is 1.
- R2: State codes are active = 2'd0, standby = 2'd1, sleep = 2'd2. A clock edge that sees `ce_n_i`=1, `rst_dev_n_i`=1 and `busy_i`=0 makes `state_o` standby after that edge.
- R3: `drv_en_o` is 1 exactly when `state_o` is not standby, `ce_n_i`=0, `oe_n_i`=0 and `rst_dev_n_i`=1. In standby it is 0 whatever the value of `oe_n_i`.
- R4: While `busy_i`=1 at an edge, the block does not enter standby after that edge, even when deselected. It enters standby at the first edge where `busy_i` is 0 and it is still deselected.
- R5: After an edge at which the address changed, sleep (2'd2) is entered at the SLEEP_CYC-th following edge at which `addr_i` still holds the same value. Default SLEEP_CYC = ACC_CYC + MARGIN_CYC = 4 + 3 = 7. Toggling `ce_n_i` or `oe_n_i` while selected neither delays nor starts sleep.
- R6: An edge at which `addr_i` differs from the address captured at the previous edge clears the stability count. If the block is not entering standby, `state_o` is active after that edge, including when it was asleep.
- R7: `hold_o` is 1 exactly while `state_o` is sleep. In sleep, `drv_en_o` still follows R3, so the latched data stays readable.
- R8: `full_lat_o` is 1 after any edge that enters or stays in standby. Once out of standby, it stays 1 until an edge at which a read is in progress (state not standby, `ce_n_i`=0, `oe_n_i`=0, `rst_dev_n_i`=1). It is 0 after that edge.
- R9: Standby takes priority over sleep: a deselected, idle block with a stable address reports standby, not sleep.
- R10: With `rst_dev_n_i`=0 the block does not enter standby, even when `ce_n_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block |
| ce_n_i | input | 1 | Chip select, active low |
| rst_dev_n_i | input | 1 | Device reset pin level, active low |
| oe_n_i | input | 1 | Output enable, active low |
| addr_i | input | AW | Read address |
| busy_i | input | 1 | Program/erase engine busy |
| state_o | output | 2 | Power state: 0 active, 1 standby, 2 sleep |
| drv_en_o | output | 1 | Data bus driver enable |
| hold_o | output | 1 | Hold latched read data (sleep) |
| full_lat_o | output | 1 | Next read needs full chip-select latency |

## Verification
The bench counts stable-address edges up to the sleep threshold and checks the edge one short of it, to catch an off-by-one that sleeps early or late. It toggles the strobes during the count, so a design that resets the counter on strobe activity never reaches sleep. It deselects the part while busy, to catch a design that drops into standby and tri-states the bus during a running operation. It also checks that the full-latency flag survives the first selected cycle out of standby and clears only after a real read, and that standby wins over a ripe sleep count.

// File: rtl/pwr_mgr_pkg.sv
package pwr_mgr_pkg;
  typedef enum logic [1:0] {
    PS_ACTIVE  = 2'd0,
    PS_STANDBY = 2'd1,
    PS_SLEEP   = 2'd2
  } pstate_e;
endpackage

// File: rtl/addr_stab.sv
module addr_stab #(
  parameter int AW        = 16,
  parameter int SLEEP_CYC = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  output logic          chg_o,
  output logic          ripe_o
);
  localparam int CW = $clog2(SLEEP_CYC + 1);
  localparam logic [CW-1:0] LIMIT  = CW'(SLEEP_CYC);
  localparam logic [CW-1:0] LIMIT1 = CW'(SLEEP_CYC - 1);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q, cnt_d;

  assign chg_o = (addr_i != addr_q);

  always_comb begin
    if (chg_o)               cnt_d = '0;
    else if (cnt_q == LIMIT) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
  end

  // threshold reached on this edge
  assign ripe_o = !chg_o && (cnt_q >= LIMIT1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      addr_q <= addr_i;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_mgr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    stby_req_i,
  input  logic    ripe_i,
  output pstate_e state_o
);
  pstate_e state_q, state_d;

  always_comb begin
    if (stby_req_i)  state_d = PS_STANDBY;
    else if (ripe_i) state_d = PS_SLEEP;
    else             state_d = PS_ACTIVE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PS_STANDBY;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/lat_track.sv
module lat_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stby_req_i,
  input  logic rd_i,
  output logic full_lat_o
);
  logic full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         full_q <= 1'b1;
    else if (stby_req_i) full_q <= 1'b1;
    else if (rd_i)       full_q <= 1'b0;
  end

  assign full_lat_o = full_q;
endmodule

// File: rtl/rd_pwr_mgr.sv
module rd_pwr_mgr
  import pwr_mgr_pkg::*;
#(
  parameter int AW         = 16,
  parameter int ACC_CYC    = 4,
  parameter int MARGIN_CYC = 3,
  parameter int SLEEP_CYC  = ACC_CYC + MARGIN_CYC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_n_i,
  input  logic          rst_dev_n_i,
  input  logic          oe_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic          busy_i,
  output logic [1:0]    state_o,
  output logic          drv_en_o,
  output logic          hold_o,
  output logic          full_lat_o
);
  pstate_e state;
  logic    chg, ripe, stby_req, rd_act;

  // deselected, out of device reset, nothing running
  assign stby_req = ce_n_i & rst_dev_n_i & ~busy_i;

  addr_stab #(.AW(AW), .SLEEP_CYC(SLEEP_CYC)) u_stab (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .addr_i(addr_i),
    .chg_o (chg),
    .ripe_o(ripe)
  );

  pwr_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stby_req_i(stby_req),
    .ripe_i    (ripe),
    .state_o   (state)
  );

  assign rd_act = (state != PS_STANDBY) & ~ce_n_i & ~oe_n_i & rst_dev_n_i;

  lat_track u_lat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stby_req_i(stby_req),
    .rd_i      (rd_act),
    .full_lat_o(full_lat_o)
  );

  assign state_o  = state;
  assign drv_en_o = rd_act;
  assign hold_o   = (state == PS_SLEEP);
endmodule

// File: rtl/rd_pwr_mgr_chk.sv
module rd_pwr_mgr_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_n_i,
  input logic          rst_dev_n_i,
  input logic          oe_n_i,
  input logic [AW-1:0] addr_i,
  input logic          busy_i,
  input logic [1:0]    state_o,
  input logic          drv_en_o,
  input logic          hold_o,
  input logic          full_lat_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assert_legal_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd3);

  assert_stby_no_drive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1) |-> !drv_en_o);

  assert_busy_blocks_stby_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (state_o != 2'd1));

  assert_addr_wakes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && addr_i != $past(addr_i)) |=> (state_o != 2'd2));

  assert_sleep_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2) |-> hold_o);

  assert_stby_full_lat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1) |-> full_lat_o);

  assert_devrst_no_stby_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_dev_n_i && !busy_i) |=> (state_o != 2'd1));
endmodule

bind rd_pwr_mgr rd_pwr_mgr_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_rd_pwr_mgr.sv
`timescale 1ns/1ps
module sim_rd_pwr_mgr;
  localparam int AW = 16;
  localparam int SLEEP = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, rdn = 1'b1, oe_n = 1'b1, busy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0] state;
  logic drv_en, hold, full_lat;

  always #5 clk = ~clk;

  rd_pwr_mgr #(.AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_n_i(ce_n), .rst_dev_n_i(rdn),
    .oe_n_i(oe_n), .addr_i(addr), .busy_i(busy),
    .state_o(state), .drv_en_o(drv_en), .hold_o(hold), .full_lat_o(full_lat)
  );

  int n_cmp = 0, n_bad = 0;
  int m_state = 1, m_stable = 0;
  logic [AW-1:0] m_addr = '0;
  bit m_full = 1'b1;
  string req = "R1";
  bit done = 1'b0;

  task automatic chk(input string r, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", r, $time, act, exp);
    end
  endtask

  task automatic compare();
    int exp_drv;
    exp_drv = (m_state != 1 && !ce_n && !oe_n && rdn) ? 1 : 0;
    chk(req, int'(state), m_state);
    chk("R3", int'(drv_en), exp_drv);
    chk("R7", int'(hold), (m_state == 2) ? 1 : 0);
    chk("R8", int'(full_lat), int'(m_full));
  endtask

  // reference update for one clock edge
  task automatic model_edge();
    bit chg, stby, rd;
    int nxt;
    chg  = (addr != m_addr);
    stby = ce_n && rdn && !busy;
    rd   = (m_state != 1) && !ce_n && !oe_n && rdn;
    nxt  = chg ? 0 : ((m_stable + 1 > SLEEP) ? SLEEP : m_stable + 1);
    m_full   = stby ? 1'b1 : (rd ? 1'b0 : m_full);
    m_state  = stby ? 1 : ((!chg && nxt >= SLEEP) ? 2 : 0);
    m_stable = nxt;
    m_addr   = addr;
  endtask

  task automatic step(input logic c, input logic r, input logic o,
                      input logic b, input logic [AW-1:0] a);
    ce_n = c; rdn = r; oe_n = o; busy = b; addr = a;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    // R2: deselected and idle stays in standby
    req = "R2";
    repeat (3) step(1, 1, 1, 0, 16'h0000);
    // R3: oe low while in standby must not drive
    req = "R3";
    step(1, 1, 0, 0, 16'h0000);
    // R8: select and read; full latency persists one edge
    req = "R8";
    step(0, 1, 0, 0, 16'h0100);
    step(0, 1, 0, 0, 16'h0100);
    step(0, 1, 0, 0, 16'h0100);
    // R5: stable address with strobes toggling reaches sleep
    req = "R5";
    for (int i = 0; i < 10; i++) step(i[0], 1, i[1], 0, 16'h0100);
    // R7: reading while asleep keeps drivers on
    req = "R7";
    step(0, 1, 0, 0, 16'h0100);
    step(0, 1, 1, 0, 16'h0100);
    // R6: address change wakes
    req = "R6";
    step(0, 1, 0, 0, 16'h0101);
    for (int i = 0; i < SLEEP - 1; i++) step(0, 1, 0, 0, 16'h0101);
    step(0, 1, 0, 0, 16'h0102);
    // R4: deselect while busy stays active
    req = "R4";
    for (int i = 0; i < 4; i++) step(1, 1, 1, 1, 16'h0102);
    step(1, 1, 1, 0, 16'h0102);
    // R9: stable address while deselected stays standby
    req = "R9";
    for (int i = 0; i < 12; i++) step(1, 1, 1, 0, 16'h0102);
    // R10: device reset low blocks standby
    req = "R10";
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 16'h0102);
    step(1, 0, 0, 0, 16'h0200);
    for (int i = 0; i < 9; i++) step(1, 0, 1, 0, 16'h0200);
    // R8: reselect after standby, no read yet keeps full latency
    req = "R8";
    step(1, 1, 1, 0, 16'h0200);
    step(0, 1, 1, 0, 16'h0300);
    step(0, 1, 1, 0, 16'h0300);
    step(0, 1, 0, 0, 16'h0300);
    step(0, 1, 0, 0, 16'h0301);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule